// File: doc/BRIEF.md
# Overlay Pixel Unpacker and Time-Slice Serializer

This block sits between an overlay frame buffer and a composite colour encoder. It takes packed frame-buffer words, picks one pixel out of the current word each time the pixel-advance strobe is sampled high, and turns that pixel into four 8-bit colour time slices. The slices leave on consecutive cycles of a clock that runs at four times the pixel rate.

Palette formats store 1, 4 or 8 bits per pixel. The pixel value goes out as an index on a palette read port, and the 32-bit entry returned one cycle later holds the four slices. The two direct formats store the slices themselves. The dense direct format packs four 4-bit slices into 16 bits and widens each nibble by repeating it. The full direct format stores four whole bytes.

Address generation and the palette contents are outside the block. The caller presents each new word together with the advance strobe of its first pixel.

Top module: `pixel_slice_unpacker`

## Requirements
- R1: While reset is high, and on the first cycle after it, `slice_out` and `pal_addr` are 0.
- R2: For a pixel whose advance strobe is sampled at edge k, slice j (j = 0..3) appears on `slice_out` after edge k+2+j. If no further advance follows, `slice_out` returns to 0 after edge k+6.
- R3: Mode 0 (1 bit per pixel): pixel i of a word is bit 8*(i/8) + 7 - (i%8). Bytes are taken in ascending order and the most-significant bit of each byte comes first. `pal_addr` is 0 or 1.
- R4: Mode 1 (4 bits per pixel): pixel i is the nibble at bit 8*(i/2) + 4*(1 - i%2). The high nibble of each byte comes first. `pal_addr` is below 16.
- R5: Mode 2 (8 bits per pixel): pixel i is byte i of the word, giving indices 0 to 255.
- R6: The palette index is presented on `pal_addr` after the advance edge and is held until the next advance. The entry read on `pal_data` one cycle later supplies slice j from bits [8j+7:8j].
- R7: Mode 3 (dense direct): pixel i is bits [16i+15:16i]. Slice j is nibble j of that halfword (least-significant nibble first), multiplied by 17.
- R8: Mode 4 (full direct): each word is one pixel, and slice j is byte j of the word.
- R9: If `line_valid` is low at an edge, `slice_out` is 0 after that edge. The slice sequence still advances.
- R10: Mode codes 5, 6 and 7 produce four zero slices per pixel.
- R11: When `word_load` is high, `word_in` is stored. If `pix_adv` is high in the same cycle, that pixel is pixel 0 of the new word. Each later advance takes the next pixel of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-pixel clock, four per pixel |
| rst | input | 1 | Synchronous active-high reset |
| line_valid | input | 1 | Active-line qualifier; low forces zero output |
| mode | input | 3 | Pixel format code (0..4 defined) |
| word_load | input | 1 | Store `word_in` and restart at pixel 0 |
| word_in | input | WORD_W (32) | Fetched frame-buffer word |
| pix_adv | input | 1 | Take the next pixel |
| pal_addr | output | 8 | Palette read index |
| pal_data | input | 4*SLICE_W (32) | Palette entry, valid one cycle after `pal_addr` |
| slice_out | output | SLICE_W (8) | Registered colour time slice |

## Verification
Some properties are checked on every cycle. Output is zero after a stretch with no advance, and output is nonzero only when `line_valid` was high. The palette index stays within range in the 1-bit and 4-bit formats and holds steady between advances. Only the directed scenarios can show which bit, nibble or byte each pixel comes from, the order of the four slices, the nibble widening, and the zeroing for unused mode codes. The scenarios compare every slice against values computed from the format rules, and they include word reloads and a dropped `line_valid`.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  typedef enum logic [2:0] {
    FMT_PAL1     = 3'd0,
    FMT_PAL4     = 3'd1,
    FMT_PAL8     = 3'd2,
    FMT_DIR_NIB  = 3'd3,
    FMT_DIR_BYTE = 3'd4
  } fmt_e;

  localparam int SLICES = 4;
  localparam int PAL_AW = 8;

  // bits per pixel of palette variant g
  function automatic int pal_bpp(input int g);
    return (g == 0) ? 1 : (g == 1) ? 4 : 8;
  endfunction
endpackage

// File: rtl/pix_picker.sv
module pix_picker
  import pixser_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_adv,
  input  logic                       word_load,
  input  logic [WORD_W-1:0]          word_in,
  input  logic [2:0]                 mode,
  output logic [PAL_AW-1:0]          pal_addr,
  output logic [SLICES*SLICE_W-1:0]  grp_direct,
  output logic                       sel_direct,
  output logic                       sel_blank,
  output logic                       adv_q
);
  localparam int GRP_W     = SLICES * SLICE_W;
  localparam int HALF_W    = GRP_W / 2;
  localparam int NIB_W     = SLICE_W / 2;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int NPIX_NIB  = WORD_W / HALF_W;
  localparam int NPIX_BYTE = WORD_W / GRP_W;

  logic [WORD_W-1:0] word_q, src;
  logic [IDX_W-1:0]  idx_q, idx;
  logic [PAL_AW-1:0] cand [3];
  logic [HALF_W-1:0] nib_pix;
  logic [GRP_W-1:0]  nib_exp, byte_pix;

  always_comb begin
    src = word_load ? word_in : word_q;
    idx = word_load ? '0 : idx_q;
  end

  // one index extractor per palette depth, MSB-first inside each byte
  for (genvar g = 0; g < 3; g++) begin : g_pal
    localparam int BPP = pal_bpp(g);
    localparam int PPB = 8 / BPP;
    int unsigned pix_i, lsb;
    logic [WORD_W-1:0] shifted;
    always_comb begin
      pix_i   = 32'(idx) % (WORD_W / BPP);
      lsb     = (pix_i / PPB) * 8 + (PPB - 1 - (pix_i % PPB)) * BPP;
      shifted = (src >> lsb) & WORD_W'((1 << BPP) - 1);
      cand[g] = shifted[PAL_AW-1:0];
    end
  end

  always_comb begin
    nib_pix  = HALF_W'(src >> ((32'(idx) % NPIX_NIB) * HALF_W));
    byte_pix = GRP_W'(src >> ((32'(idx) % NPIX_BYTE) * GRP_W));
  end

  for (genvar j = 0; j < SLICES; j++) begin : g_widen
    assign nib_exp[j*SLICE_W +: SLICE_W] = {2{nib_pix[j*NIB_W +: NIB_W]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      idx_q      <= '0;
      pal_addr   <= '0;
      grp_direct <= '0;
      sel_direct <= 1'b0;
      sel_blank  <= 1'b0;
      adv_q      <= 1'b0;
    end else begin
      adv_q <= pix_adv;
      if (word_load) word_q <= word_in;
      if (pix_adv) begin
        idx_q <= idx + 1'b1;
        case (fmt_e'(mode))
          FMT_PAL1:     begin pal_addr <= cand[0]; sel_direct <= 1'b0; sel_blank <= 1'b0; end
          FMT_PAL4:     begin pal_addr <= cand[1]; sel_direct <= 1'b0; sel_blank <= 1'b0; end
          FMT_PAL8:     begin pal_addr <= cand[2]; sel_direct <= 1'b0; sel_blank <= 1'b0; end
          FMT_DIR_NIB:  begin grp_direct <= nib_exp;  sel_direct <= 1'b1; sel_blank <= 1'b0; end
          FMT_DIR_BYTE: begin grp_direct <= byte_pix; sel_direct <= 1'b1; sel_blank <= 1'b0; end
          default:      begin sel_blank <= 1'b1; end
        endcase
      end else if (word_load) begin
        idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/slice_ser.sv
module slice_ser
  import pixser_pkg::*;
#(
  parameter int SLICE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_valid,
  input  logic                      adv_q,
  input  logic                      sel_direct,
  input  logic                      sel_blank,
  input  logic [SLICES*SLICE_W-1:0] grp_direct,
  input  logic [SLICES*SLICE_W-1:0] pal_data,
  output logic [SLICE_W-1:0]        slice_out
);
  localparam int GRP_W = SLICES * SLICE_W;
  localparam int CNT_W = $clog2(SLICES);

  logic             adv2, dir2, blank2;
  logic [GRP_W-1:0] grp2, grp_now, shift_q;
  logic [CNT_W-1:0] left_q;

  // align direct data with the palette read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      adv2   <= 1'b0;
      dir2   <= 1'b0;
      blank2 <= 1'b0;
      grp2   <= '0;
    end else begin
      adv2   <= adv_q;
      dir2   <= sel_direct;
      blank2 <= sel_blank;
      grp2   <= grp_direct;
    end
  end

  always_comb begin
    if (blank2)    grp_now = '0;
    else if (dir2) grp_now = grp2;
    else           grp_now = pal_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      left_q    <= '0;
      slice_out <= '0;
    end else if (adv2) begin
      shift_q   <= grp_now >> SLICE_W;
      left_q    <= CNT_W'(SLICES - 1);
      slice_out <= line_valid ? grp_now[SLICE_W-1:0] : '0;
    end else if (left_q != '0) begin
      shift_q   <= shift_q >> SLICE_W;
      left_q    <= left_q - 1'b1;
      slice_out <= line_valid ? shift_q[SLICE_W-1:0] : '0;
    end else begin
      slice_out <= '0;
    end
  end
endmodule

// File: rtl/pixel_slice_unpacker.sv
module pixel_slice_unpacker
  import pixser_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       line_valid,
  input  logic [2:0]                 mode,
  input  logic                       word_load,
  input  logic [WORD_W-1:0]          word_in,
  input  logic                       pix_adv,
  output logic [PAL_AW-1:0]          pal_addr,
  input  logic [SLICES*SLICE_W-1:0]  pal_data,
  output logic [SLICE_W-1:0]         slice_out
);
  localparam int GRP_W = SLICES * SLICE_W;

  logic [GRP_W-1:0] grp_direct;
  logic             sel_direct, sel_blank, adv_q;

  pix_picker #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) picker_i (
    .clk(clk), .rst(rst), .pix_adv(pix_adv), .word_load(word_load),
    .word_in(word_in), .mode(mode), .pal_addr(pal_addr),
    .grp_direct(grp_direct), .sel_direct(sel_direct),
    .sel_blank(sel_blank), .adv_q(adv_q)
  );

  slice_ser #(.SLICE_W(SLICE_W)) ser_i (
    .clk(clk), .rst(rst), .line_valid(line_valid), .adv_q(adv_q),
    .sel_direct(sel_direct), .sel_blank(sel_blank),
    .grp_direct(grp_direct), .pal_data(pal_data), .slice_out(slice_out)
  );
endmodule

// File: rtl/pixel_slice_unpacker_sva.sv
module pixel_slice_unpacker_sva #(
  parameter int SLICE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               line_valid,
  input logic [2:0]         mode,
  input logic               pix_adv,
  input logic [7:0]         pal_addr,
  input logic [SLICE_W-1:0] slice_out
);
  logic [2:0] idle;

  always_ff @(posedge clk) begin
    if (rst)            idle <= 3'd6;
    else if (pix_adv)   idle <= 3'd0;
    else if (idle != 3'd6) idle <= idle + 3'd1;
  end

  assert_quiet_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (idle == 3'd6) |-> (slice_out == '0));

  assert_pal1_index_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_adv && mode == 3'd0) |=> (pal_addr[7:1] == 7'd0));

  assert_pal4_index_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_adv && mode == 3'd1) |=> (pal_addr[7:4] == 4'd0));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !pix_adv |=> $stable(pal_addr));

  assert_blank_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (slice_out != '0) |-> $past(line_valid));
endmodule

bind pixel_slice_unpacker pixel_slice_unpacker_sva #(.SLICE_W(SLICE_W)) sva_i (
  .clk(clk), .rst(rst), .line_valid(line_valid), .mode(mode),
  .pix_adv(pix_adv), .pal_addr(pal_addr), .slice_out(slice_out)
);

// File: tb/pixel_slice_unpacker_tb_top.sv
module pixel_slice_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        line_valid;
  logic [2:0]  mode;
  logic        word_load;
  logic [31:0] word_in;
  logic        pix_adv;
  logic [7:0]  pal_addr;
  logic [31:0] pal_data;
  logic [7:0]  slice_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] wbuf [8];

  always #10 clk = ~clk;  // 50 MHz

  pixel_slice_unpacker dut_i (
    .clk(clk), .rst(rst), .line_valid(line_valid), .mode(mode),
    .word_load(word_load), .word_in(word_in), .pix_adv(pix_adv),
    .pal_addr(pal_addr), .pal_data(pal_data), .slice_out(slice_out)
  );

  // palette model: entry byte j is the slice j value (R6)
  function automatic logic [7:0] pal_fn(input logic [7:0] a, input int j);
    case (j)
      0: return a;
      1: return ~a;
      2: return a + 8'd3;
      default: return a ^ 8'h5A;
    endcase
  endfunction

  always @(posedge clk)
    pal_data <= {pal_fn(pal_addr, 3), pal_fn(pal_addr, 2), pal_fn(pal_addr, 1), pal_fn(pal_addr, 0)};

  function automatic logic [7:0] exp_slice(input int m, input logic [31:0] w, input int p, input int j);
    logic [7:0] ix;
    case (m)
      0: begin ix = 8'((w >> ((p/8)*8 + 7 - p%8)) & 32'h1);          return pal_fn(ix, j); end
      1: begin ix = 8'((w >> ((p/2)*8 + (1 - p%2)*4)) & 32'hF);      return pal_fn(ix, j); end
      2: begin ix = 8'((w >> (8*p)) & 32'hFF);                       return pal_fn(ix, j); end
      3: return 8'(((w >> (16*p + 4*j)) & 32'hF) * 17);
      4: return 8'(w >> (8*j));
      default: return 8'h00;
    endcase
  endfunction

  function automatic int ppw(input int m);
    case (m)
      0: return 32;
      1: return 8;
      2: return 4;
      3: return 2;
      4: return 1;
      default: return 4;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3 R6";
      1: return "R4 R6 R11";
      2: return "R5 R6 R11";
      3: return "R7";
      4: return "R8 R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // streams np pixels at one advance per four cycles, checking each slice (R2)
  task automatic run_stream(input int m, input int np, input int lv_drop);
    int  per;
    logic lv_prev;
    per = ppw(m);
    lv_prev = 1'b1;
    mode = 3'(m);
    for (int t = 0; t <= 4*np + 4; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        int q, j;
        logic [7:0] e;
        q = (t - 3) / 4;
        j = (t - 3) % 4;
        e = (q < np) ? exp_slice(m, wbuf[q / per], q % per, j) : 8'h00;
        if (!lv_prev) chk("R9 blanked slice", slice_out, 8'h00);
        else if (q >= np) chk("R2 idle after last slice", slice_out, 8'h00);
        else chk(mode_tag(m), slice_out, e);
      end
      pix_adv    = (t % 4 == 0) && (t / 4 < np);
      word_load  = pix_adv && ((t / 4) % per == 0);
      word_in    = wbuf[((t / 4) / per) % 8];
      line_valid = (t != lv_drop);
      lv_prev    = line_valid;
    end
    pix_adv = 1'b0;
    word_load = 1'b0;
    line_valid = 1'b1;
  endtask

  task automatic t_reset;
    rst = 1'b1; line_valid = 1'b1; mode = 3'd0; word_load = 1'b0;
    word_in = '0; pix_adv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 slice in reset", slice_out, 8'h00);
    chk("R1 addr in reset", pal_addr, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 slice after reset", slice_out, 8'h00);
    chk("R1 addr after reset", pal_addr, 8'h00);
  endtask

  task automatic t_pal1;
    wbuf[0] = 32'hC3A5_0F96;
    run_stream(0, 16, -1);
  endtask

  task automatic t_pal4;  // crosses a word reload (R11)
    wbuf[0] = 32'h1F2E_3D4C; wbuf[1] = 32'h5B6A_7988;
    run_stream(1, 10, -1);
  endtask

  task automatic t_pal8_blank;  // line_valid drop mid pixel (R9)
    wbuf[0] = 32'h80FF_4117; wbuf[1] = 32'h02C8_E9A6;
    run_stream(2, 6, 9);
  endtask

  task automatic t_dir_nib;
    wbuf[0] = 32'hF05A_1C93; wbuf[1] = 32'h7E28_B6D4;
    run_stream(3, 3, -1);
  endtask

  task automatic t_dir_byte;  // new word every pixel (R11)
    wbuf[0] = 32'h11F0_7C2A; wbuf[1] = 32'h9955_0304; wbuf[2] = 32'hFEDC_BA98;
    run_stream(4, 3, -1);
  endtask

  task automatic t_unused;  // unused code gives zero slices (R10)
    wbuf[0] = 32'hFFFF_FFFF;
    run_stream(6, 2, -1);
  endtask

  initial begin
    t_reset();
    t_pal1();
    t_pal4();
    t_pal8_blank();
    t_dir_nib();
    t_dir_byte();
    t_unused();
    t_pal1();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule